// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block is a slave on a two-wire serial port, with one clock line and one open-drain data line. Through it, a host reaches a bank of byte-wide control registers inside the chip. Both line inputs are sampled by a much faster system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter. The block then decodes the framing events from the clean levels.

A transaction opens with a START. The first byte is a device address that carries a direction bit, and one bit pair of that address is set by a strap pin. A write transaction sends a register address next, then any number of data bytes, and each one goes to the register the internal pointer names. A read transaction returns bytes starting at the current pointer. To read a chosen register, the host writes its address, issues a repeated START and then sends the read-direction address.

Writes stop at the last register in a particular way: the byte that follows a write to the last register becomes a new start address and is not stored. Reads wrap from the last register back to register 0. The data pin is never driven high. `wire_dat_oe` is an enable that pulls the line low. The full register bank is presented flat on `bank_flat` for the logic it controls.

Top module: `twr_slave`

## Requirements
- R1: During and after reset every register is 00h, the pointer is 0 and `wire_dat_oe` is low.
- R2: A falling data line while the clock is high is START. A rising data line while the clock is high is STOP. After STOP the slave stays silent and acknowledges nothing until the next START.
- R3: The device address byte, sent MSB first, is 11101 in bits 7:3, the inverse of `addr_strap` in bit 2, `addr_strap` in bit 1, and the direction in bit 0 (0 write, 1 read). This gives EAh/EBh with the strap at 1 and ECh/EDh with the strap at 0. A matching byte is acknowledged.
- R4: A device address that does not match gets no acknowledge. Every byte after it is ignored until the next START, and the registers keep their values.
- R5: The byte after a write-direction address loads its bits 6:0 into the pointer. Its bit 7 is ignored.
- R6: Every accepted write-side byte is acknowledged. The slave holds the line low through the whole high phase of the ninth clock and changes its drive only while the clock is low.
- R7: Each data byte written goes to the register the pointer names, and the pointer then advances by one. After a write to register 4Fh, the next byte received becomes the new pointer value instead of data, and writes continue from there.
- R8: A read sends the register the pointer names, MSB first, and then advances the pointer. After 4Fh the pointer wraps to 00h.
- R9: When the master does not acknowledge a read byte, the slave releases the line and drives nothing more until the next START.
- R10: A repeated START ends the current sequence, keeps the pointer, and restarts device-address reception. A following read returns the register named by the pointer.
- R11: A pulse of two system clocks or fewer on the clock line is filtered out and has no effect on the transfer.
- R12: Register i appears on `bank_flat[8*i+7 : 8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the line bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Strap that selects the device address pair |
| wire_clk_i | input | 1 | Serial clock line as seen at the pad |
| wire_dat_i | input | 1 | Serial data line as seen at the pad |
| wire_dat_oe | output | 1 | When high, pulls the data line low |
| bank_flat | output | NREG*8 | All registers, register i in byte lane i |

## Verification
A single received byte can have two effects. It can complete the write to register 4Fh and arm the pointer reload in the same cycle. Or, when the reload is already armed, it can load the pointer in the cycle where a write would otherwise happen. To provoke both, the bench writes 4Eh and 4Fh, then sends a byte that must steer the pointer, then sends data. It judges the result by where that data lands in the bank and by the acknowledges given. A read wrap from 4Fh is checked in the same way, by reading across the boundary and comparing against previously written registers. The bench also injects clock glitches inside a write, to confirm that the filter keeps them out of the bit count.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int REG_W = 8;
  localparam logic [4:0] DEV_PREFIX = 5'b11101;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_REG,
    S_REG_ACK,
    S_WR,
    S_WR_ACK,
    S_TX,
    S_MACK
  } twr_state_t;
endpackage

// File: rtl/twr_deglitch.sv
module twr_deglitch #(
  parameter int LANES = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] clean
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0]       sync_q;
    logic [DEPTH-1:0] hist_q;
    logic             lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        lvl_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        hist_q <= {hist_q[DEPTH-2:0], sync_q[1]};
        if (&hist_q)       lvl_q <= 1'b1;
        else if (~|hist_q) lvl_q <= 1'b0;
      end
    end

    assign clean[g] = lvl_q;
  end
endmodule

// File: rtl/twr_regbank.sv
module twr_regbank import twr_pkg::*; #(
  parameter int NREG  = 80,
  parameter int PTR_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [PTR_W-1:0]      waddr,
  input  logic [REG_W-1:0]      wdata,
  input  logic [PTR_W-1:0]      raddr,
  output logic [REG_W-1:0]      rdata,
  output logic [NREG*REG_W-1:0] bank_flat
);
  logic [REG_W-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we && (int'(waddr) < NREG)) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(raddr) == i) rdata = mem_q[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bank_flat[g*REG_W +: REG_W] = mem_q[g];
  end
endmodule

// File: rtl/twr_engine.sv
module twr_engine import twr_pkg::*; #(
  parameter int NREG  = 80,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             strap,
  input  logic [REG_W-1:0] rdata,
  output logic             sda_oe,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [REG_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr,
  output logic             reload,
  output twr_state_t       state,
  output logic             start_ev,
  output logic             stop_ev
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  logic             scl_d, sda_d, rw_q, mack_q;
  logic [3:0]       cnt;
  logic [REG_W-1:0] shreg;
  logic             scl_rise, scl_fall, addr_hit, last_bit;

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
  assign addr_hit = (shreg[7:3] == DEV_PREFIX) && (shreg[2] == ~strap) && (shreg[1] == strap);
  assign last_bit = (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      state  <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b1;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
      ptr    <= '0;
      reload <= 1'b0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      we    <= 1'b0;
      if (stop_ev) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_REG, S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[REG_W-2:0], sda_f};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && last_bit) begin
              if (state == S_DEV) begin
                if (addr_hit) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_DEV_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_REG) begin
                ptr    <= shreg[PTR_W-1:0];
                reload <= 1'b0;
                sda_oe <= 1'b1;
                state  <= S_REG_ACK;
              end else begin
                if (reload) begin
                  ptr    <= shreg[PTR_W-1:0];
                  reload <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= shreg;
                  if (ptr == LAST) reload <= 1'b1;
                  else             ptr    <= ptr + 1'b1;
                end
                sda_oe <= 1'b1;
                state  <= S_WR_ACK;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[REG_W-1];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_REG;
              end
            end
          end
          S_REG_ACK, S_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_WR;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (last_bit) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
                ptr    <= (ptr == LAST) ? '0 : ptr + 1'b1;
              end else begin
                shreg  <= {shreg[REG_W-2:0], 1'b0};
                sda_oe <= ~shreg[REG_W-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_q <= sda_f;
            end else if (scl_fall) begin
              if (!mack_q) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[REG_W-1];
                cnt    <= '0;
                state  <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twr_slave.sv
module twr_slave import twr_pkg::*; #(
  parameter int NREG  = 80,
  parameter int FILT  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_strap,
  input  logic                  wire_clk_i,
  input  logic                  wire_dat_i,
  output logic                  wire_dat_oe,
  output logic [NREG*REG_W-1:0] bank_flat
);
  localparam int PTR_W = 7;

  logic [1:0]       clean;
  logic             scl_f, sda_f;
  logic             we, reload, start_ev, stop_ev;
  logic [PTR_W-1:0] waddr, ptr;
  logic [REG_W-1:0] wdata, rdata;
  twr_state_t       state;

  twr_deglitch #(.LANES(2), .DEPTH(FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw({wire_dat_i, wire_clk_i}), .clean(clean)
  );

  assign scl_f = clean[0];
  assign sda_f = clean[1];

  twr_engine #(.NREG(NREG), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .strap(addr_strap),
    .rdata(rdata), .sda_oe(wire_dat_oe), .we(we), .waddr(waddr), .wdata(wdata),
    .ptr(ptr), .reload(reload), .state(state), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twr_regbank #(.NREG(NREG), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .bank_flat(bank_flat)
  );
endmodule

// File: rtl/twr_checker.sv
module twr_checker import twr_pkg::*; #(
  parameter int NREG  = 80,
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             sda_oe,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             we,
  input logic [PTR_W-1:0] waddr,
  input logic             reload,
  input logic [PTR_W-1:0] ptr,
  input twr_state_t       state
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (ptr == '0 && !sda_oe));

  p_stop_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == S_IDLE && !sda_oe));

  p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  p_drive_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_f);

  p_reload_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == LAST) |-> reload);

  p_read_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_TX && state == S_MACK && $past(ptr) == LAST) |-> ptr == '0);

  p_restart_keeps_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == S_DEV && $stable(ptr)));
endmodule

bind twr_slave twr_checker #(.NREG(NREG), .PTR_W(PTR_W)) u_twr_checker (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(wire_dat_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .we(we), .waddr(waddr),
  .reload(reload), .ptr(ptr), .state(state)
);

// File: tb/twr_slave_bench.sv
module twr_slave_bench;
  localparam int NREG = 80;
  localparam int Q    = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, strap, m_scl, m_sda, oe, line;
  logic [NREG*8-1:0] bank;
  int n_chk = 0, n_bad = 0;
  bit glitch = 1'b0;
  int exp_q[$];
  int got_q[$];
  string tag_q[$];

  assign line = m_sda & ~oe;

  twr_slave #(.NREG(NREG)) u_twr_slave (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .wire_clk_i(m_scl),
    .wire_dat_i(line), .wire_dat_oe(oe), .bank_flat(bank)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] regv(int i);
    return bank[i*8 +: 8];
  endfunction

  task automatic put_bit(bit b, output bit seen);
    m_sda = b;
    tick(Q);
    m_scl = 1'b1;
    if (glitch) begin
      tick(3); m_scl = 1'b0; tick(2); m_scl = 1'b1; tick(Q - 5);
    end else begin
      tick(Q);
    end
    seen = line;
    tick(Q);
    m_scl = 1'b0;
    tick(Q);
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(logic [7:0] b, bit exp_ack, string tag);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    check(!s == exp_ack, tag, int'(!s), int'(exp_ack));
  endtask

  task automatic rd_byte(bit nack, logic [7:0] e, string tag);
    bit s;
    logic [7:0] b;
    exp_q.push_back(int'(e));
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
    end
    put_bit(nack, s);
    got_q.push_back(int'(b));
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        automatic int g = got_q.pop_front();
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit all_zero;
    rst_n = 1'b0; strap = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
    tick(5);
    // R1: reset state
    check(oe == 1'b0, "R1 oe", int'(oe), 0);
    rst_n = 1'b1;
    tick(5);
    all_zero = 1'b1;
    for (int i = 0; i < NREG; i++) if (regv(i) != 8'h00) all_zero = 1'b0;
    check(all_zero, "R1 bank", int'(all_zero), 1);

    // R3 R5 R6 R7: write EA, reg byte 85h (bit7 ignored -> 05)
    start_c();
    wr_byte(8'hEA, 1'b1, "R3 EA ack");
    wr_byte(8'h85, 1'b1, "R5 reg ack");
    wr_byte(8'h11, 1'b1, "R6 d0 ack");
    wr_byte(8'h22, 1'b1, "R6 d1 ack");
    wr_byte(8'h33, 1'b1, "R6 d2 ack");
    stop_c();
    check(regv(5) == 8'h11, "R5 reg05", regv(5), 8'h11);
    check(regv(6) == 8'h22, "R7 reg06", regv(6), 8'h22);
    check(regv(7) == 8'h33, "R12 reg07", regv(7), 8'h33);

    // R10 R8: set pointer, repeated start, read
    start_c();
    wr_byte(8'hEA, 1'b1, "R10 EA ack");
    wr_byte(8'h06, 1'b1, "R10 reg ack");
    start_c();
    wr_byte(8'hEB, 1'b1, "R3 EB ack");
    rd_byte(1'b0, 8'h22, "R10 rd06");
    rd_byte(1'b1, 8'h33, "R8 rd07");
    stop_c();

    // R4: mismatch ignored
    start_c();
    wr_byte(8'hEC, 1'b0, "R4 EC nack");
    wr_byte(8'h05, 1'b0, "R4 follow nack");
    wr_byte(8'h99, 1'b0, "R4 data nack");
    stop_c();
    check(regv(5) == 8'h11, "R4 reg05 kept", regv(5), 8'h11);

    // R3: strap 0
    strap = 1'b0;
    tick(4);
    start_c();
    wr_byte(8'hEA, 1'b0, "R3 EA rejected strap0");
    stop_c();
    start_c();
    wr_byte(8'hEC, 1'b1, "R3 EC ack");
    wr_byte(8'h00, 1'b1, "R3 reg ack");
    wr_byte(8'hC0, 1'b1, "R7 d ack");
    wr_byte(8'hC1, 1'b1, "R7 d ack");
    stop_c();

    // R7: write across last register
    start_c();
    wr_byte(8'hEC, 1'b1, "R7 EC ack");
    wr_byte(8'h4E, 1'b1, "R7 reg ack");
    wr_byte(8'hA1, 1'b1, "R7 4E ack");
    wr_byte(8'hA2, 1'b1, "R7 4F ack");
    wr_byte(8'h03, 1'b1, "R7 reload ack");
    wr_byte(8'hB3, 1'b1, "R7 new ack");
    stop_c();
    check(regv(8'h4E) == 8'hA1, "R7 reg4E", regv(8'h4E), 8'hA1);
    check(regv(8'h4F) == 8'hA2, "R7 reg4F", regv(8'h4F), 8'hA2);
    check(regv(0) == 8'hC0, "R7 reg00 kept", regv(0), 8'hC0);
    check(regv(3) == 8'hB3, "R7 reg03", regv(3), 8'hB3);
    check(regv(4) == 8'h00, "R7 reg04", regv(4), 8'h00);

    // R8 R9: read wrap, then NACK release
    start_c();
    wr_byte(8'hEC, 1'b1, "R8 EC ack");
    wr_byte(8'h4F, 1'b1, "R8 reg ack");
    start_c();
    wr_byte(8'hED, 1'b1, "R3 ED ack");
    rd_byte(1'b0, 8'hA2, "R8 rd4F");
    rd_byte(1'b0, 8'hC0, "R8 wrap rd00");
    rd_byte(1'b1, 8'hC1, "R8 rd01");
    check(oe == 1'b0, "R9 released", int'(oe), 0);
    rd_byte(1'b1, 8'hFF, "R9 silent");
    stop_c();

    // R2: no start after stop -> no ack
    wr_byte(8'hEC, 1'b0, "R2 no start");
    stop_c();

    // R11: clock glitches inside a write
    glitch = 1'b1;
    start_c();
    wr_byte(8'hEC, 1'b1, "R11 EC ack");
    wr_byte(8'h20, 1'b1, "R11 reg ack");
    wr_byte(8'h5C, 1'b1, "R11 d ack");
    glitch = 1'b0;
    stop_c();
    check(regv(8'h20) == 8'h5C, "R11 reg20", regv(8'h20), 8'h5C);
    check(regv(8'h21) == 8'h00, "R11 reg21", regv(8'h21), 8'h00);

    tick(4);
    wait (got_q.size() == 0);
    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule